// File: doc/BRIEF.md
# Delay-Slot Fetch Address Sequencer

This block produces the instruction fetch address for a 32-bit core whose instructions are fixed one-word units and whose control transfers take effect one instruction late. A current/upcoming address pair is held in registers. Each cycle the decoder reports what the instruction at the current address is: no transfer, a conditional branch, branch-always, branch-never or a call. It also supplies the resolved condition bit, the annul bit and the displacement field. From these the sequencer advances the pair and flags the next fetched instruction as squashed when the annul rules require it.

A transfer writes its target into the upcoming address, so the instruction that follows the transfer (the delay slot) is always fetched. With annul clear, the delay slot always runs. With annul set, a conditional branch squashes the slot only when it falls through. Branch-always and branch-never squash the slot whenever annul is set. A call never squashes its slot and raises a link-write strobe that carries its own address, which the register file stores as the return address. A squashed instruction has no effect on sequencing. A stall input freezes all state.

Top module: `dslot_pc_seq`

## Requirements
- R1: A synchronous active-high reset sets the fetch address to 0, clears the squash flag, and makes the first advance after reset go to address 4.
- R2: With no transfer (kind code 0) and no stall, the fetch address moves to the upcoming address, and the upcoming address becomes that address plus 4.
- R3: A conditional branch (kind code 1) with condition 1 fetches its delay slot next, then the branch address plus four times the sign-extended low 22 bits of the displacement.
- R4: The branch displacement is signed, so a value with bit 21 set moves the target below the branch address.
- R5: A conditional branch with condition 0 and annul 0 runs its delay slot unsquashed and then continues at the branch address plus 8.
- R6: A conditional branch with condition 0 and annul 1 fetches its delay slot with the squash flag set, then continues at the branch address plus 8. With condition 1 and annul 1, the slot is not squashed.
- R7: Branch-always (kind code 2) transfers to its target after the delay slot and squashes the slot when annul is 1. With annul 0, it runs the slot.
- R8: Branch-never (kind code 3) never transfers. It squashes its delay slot when annul is 1 and runs it otherwise.
- R9: A call (kind code 4) transfers to the call address plus four times the full 30-bit displacement (which wraps modulo 2^32), never squashes its delay slot, and in its own cycle raises the link strobe with the link address equal to the call's address.
- R10: While the stall input is 1, the fetch address, upcoming address and squash flag hold, and the link strobe stays low.
- R11: When the squash flag is set, the control inputs are ignored: sequencing proceeds as for no transfer, the link strobe stays low, and the flag clears on the next advance.
- R12: Kind codes 5 to 7 are treated as no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Freeze all sequencing state this cycle |
| kind_i | input | 3 | Control class of the instruction at the fetch address (0 none, 1 conditional, 2 always, 3 never, 4 call) |
| cond_i | input | 1 | Resolved condition for a conditional branch |
| annul_i | input | 1 | Annul bit of the branch |
| disp_i | input | 30 | Word displacement; branches use bits 21:0, a call uses all bits |
| fetch_pc_o | output | 32 | Current fetch address |
| squash_o | output | 1 | The instruction at the fetch address is annulled |
| link_we_o | output | 1 | Return address write strobe for a call |
| link_addr_o | output | 32 | Return address value (the call's own address) |

## Verification
The assertions assume that the decoder describes the instruction that sits at the current fetch address. They also assume that the condition and annul bits are stable for the whole cycle, and that reset is held for at least one clock edge. The stimulus applies each decoded instruction on the falling edge, for exactly the address the bench expects the sequencer to be fetching. Control inputs are driven on squashed slots and stalled cycles only to show that they have no effect. Reset is applied both at start-up and in the middle of a run.

// File: rtl/dslot_pkg.sv
package dslot_pkg;

    localparam int XLEN    = 32;
    localparam int BDISP_W = 22;
    localparam int CDISP_W = 30;
    localparam int KIND_W  = 3;
    localparam int INSN_BYTES = 4;

    typedef enum logic [KIND_W-1:0] {
        CT_NONE  = 3'd0,
        CT_BCOND = 3'd1,
        CT_BALW  = 3'd2,
        CT_BNEV  = 3'd3,
        CT_CALL  = 3'd4
    } ctl_kind_e;

    typedef struct packed {
        logic redirect;
        logic squash_nxt;
        logic link_we;
        logic use_call_disp;
    } seq_dec_t;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] npc;
        logic            squash;
    } seq_state_t;

endpackage

// File: rtl/dslot_target.sv
module dslot_target
    import dslot_pkg::*;
#(
    parameter int AW  = XLEN,
    parameter int BDW = BDISP_W,
    parameter int CDW = CDISP_W
) (
    input  logic [AW-1:0]  base_i,
    input  logic [CDW-1:0] disp_i,
    input  logic           use_call_i,
    output logic [AW-1:0]  target_o
);
    localparam int BEXT = AW - BDW - 2;
    localparam int CEXT = AW - CDW - 2;

    logic [AW-1:0] boff;
    logic [AW-1:0] coff;

    assign boff = {{BEXT{disp_i[BDW-1]}}, disp_i[BDW-1:0], 2'b00};

    generate
        if (CEXT > 0) begin : g_call_sext
            assign coff = {{CEXT{disp_i[CDW-1]}}, disp_i, 2'b00};
        end else begin : g_call_full
            assign coff = {disp_i[AW-3:0], 2'b00};
        end
    endgenerate

    assign target_o = base_i + (use_call_i ? coff : boff);

endmodule

// File: rtl/dslot_decide.sv
module dslot_decide
    import dslot_pkg::*;
(
    input  logic [KIND_W-1:0] kind_i,
    input  logic              squashed_i,
    input  logic              cond_i,
    input  logic              annul_i,
    input  logic              stall_i,
    output seq_dec_t          dec_o
);
    ctl_kind_e kind;

    always_comb begin
        kind  = squashed_i ? CT_NONE : ctl_kind_e'(kind_i);
        dec_o = '0;
        case (kind)
            CT_BCOND: begin
                dec_o.redirect   = cond_i;
                dec_o.squash_nxt = annul_i & ~cond_i;
            end
            CT_BALW: begin
                dec_o.redirect   = 1'b1;
                dec_o.squash_nxt = annul_i;
            end
            CT_BNEV: begin
                dec_o.squash_nxt = annul_i;
            end
            CT_CALL: begin
                dec_o.redirect      = 1'b1;
                dec_o.use_call_disp = 1'b1;
                dec_o.link_we       = ~stall_i;
            end
            default: dec_o = '0;
        endcase
    end

endmodule

// File: rtl/dslot_pc_seq.sv
module dslot_pc_seq
    import dslot_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               stall_i,
    input  logic [KIND_W-1:0]  kind_i,
    input  logic               cond_i,
    input  logic               annul_i,
    input  logic [CDISP_W-1:0] disp_i,
    output logic [XLEN-1:0]    fetch_pc_o,
    output logic               squash_o,
    output logic               link_we_o,
    output logic [XLEN-1:0]    link_addr_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    seq_state_t      st_q;
    seq_dec_t        dec;
    logic [XLEN-1:0] target;

    dslot_decide u_decide (
        .kind_i     (kind_i),
        .squashed_i (st_q.squash),
        .cond_i     (cond_i),
        .annul_i    (annul_i),
        .stall_i    (stall_i),
        .dec_o      (dec)
    );

    dslot_target #(
        .AW  (XLEN),
        .BDW (BDISP_W),
        .CDW (CDISP_W)
    ) u_target (
        .base_i     (st_q.pc),
        .disp_i     (disp_i),
        .use_call_i (dec.use_call_disp),
        .target_o   (target)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.pc     <= '0;
            st_q.npc    <= STEP;
            st_q.squash <= 1'b0;
        end else if (!stall_i) begin
            st_q.pc     <= st_q.npc;
            st_q.npc    <= dec.redirect ? target : st_q.npc + STEP;
            st_q.squash <= dec.squash_nxt;
        end
    end

    assign fetch_pc_o  = st_q.pc;
    assign squash_o    = st_q.squash;
    assign link_we_o   = dec.link_we;
    assign link_addr_o = st_q.pc;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (st_q.pc == '0 && st_q.npc == STEP && !st_q.squash));

    // R2
    advance_chk: assert property (@(posedge clk) disable iff (rst)
        !stall_i |=> (st_q.pc == $past(st_q.npc)));

    // R10
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> ($stable(st_q.pc) && $stable(st_q.npc) && $stable(st_q.squash)));

    // R11
    squashed_seq_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.squash && !stall_i) |=> (st_q.npc == $past(st_q.npc) + STEP && !st_q.squash));

    // R6
    squash_needs_annul_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(st_q.squash) |-> $past(annul_i));

    // R9
    link_only_call_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (kind_i == 3'd4 && !squash_o && !stall_i));

    // R9
    call_no_squash_chk: assert property (@(posedge clk) disable iff (rst)
        link_we_o |=> !st_q.squash);

endmodule

// File: tb/tb_dslot_pc_seq.sv
module tb_dslot_pc_seq;

    logic        clk = 1'b0;
    logic        rst;
    logic        stall_i;
    logic [2:0]  kind_i;
    logic        cond_i;
    logic        annul_i;
    logic [29:0] disp_i;
    logic [31:0] fetch_pc_o;
    logic        squash_o;
    logic        link_we_o;
    logic [31:0] link_addr_o;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    dslot_pc_seq dut (
        .clk         (clk),
        .rst         (rst),
        .stall_i     (stall_i),
        .kind_i      (kind_i),
        .cond_i      (cond_i),
        .annul_i     (annul_i),
        .disp_i      (disp_i),
        .fetch_pc_o  (fetch_pc_o),
        .squash_o    (squash_o),
        .link_we_o   (link_we_o),
        .link_addr_o (link_addr_o)
    );

    // row: exp_pc[68:37] exp_sq[36] kind[35:33] cond[32] annul[31] disp[30:1] stall[0]
    localparam int NV = 26;
    localparam logic [68:0] VEC [0:NV-1] = '{
        {32'd0,   1'b0, 3'd0, 1'b0, 1'b0, 30'd0,          1'b0}, // R2
        {32'd4,   1'b0, 3'd1, 1'b1, 1'b0, 30'd16,         1'b0}, // R3 taken -> 68
        {32'd8,   1'b0, 3'd0, 1'b0, 1'b0, 30'd0,          1'b0}, // R3 delay slot
        {32'd68,  1'b0, 3'd1, 1'b0, 1'b0, 30'd5,          1'b0}, // R5
        {32'd72,  1'b0, 3'd0, 1'b0, 1'b0, 30'd0,          1'b0}, // R5 slot runs
        {32'd76,  1'b0, 3'd1, 1'b0, 1'b1, 30'd5,          1'b0}, // R6 fall through annul
        {32'd80,  1'b1, 3'd2, 1'b0, 1'b1, 30'd100,        1'b0}, // R11 ignored
        {32'd84,  1'b0, 3'd1, 1'b1, 1'b1, 30'h3FFFFC,     1'b0}, // R4 back to 68
        {32'd88,  1'b0, 3'd0, 1'b0, 1'b0, 30'd0,          1'b0}, // R6 taken slot kept
        {32'd68,  1'b0, 3'd2, 1'b0, 1'b1, 30'd8,          1'b0}, // R7 always annul -> 100
        {32'd72,  1'b1, 3'd0, 1'b0, 1'b0, 30'd0,          1'b0}, // R7 slot squashed
        {32'd100, 1'b0, 3'd3, 1'b0, 1'b0, 30'd9,          1'b0}, // R8 never
        {32'd104, 1'b0, 3'd0, 1'b0, 1'b0, 30'd0,          1'b0}, // R8
        {32'd108, 1'b0, 3'd3, 1'b1, 1'b1, 30'd9,          1'b0}, // R8 never annul
        {32'd112, 1'b1, 3'd4, 1'b0, 1'b0, 30'd3,          1'b0}, // R11 call ignored
        {32'd116, 1'b0, 3'd4, 1'b0, 1'b1, 30'd64,         1'b0}, // R9 -> 372
        {32'd120, 1'b0, 3'd1, 1'b1, 1'b0, 30'd10,         1'b1}, // R10 stall
        {32'd120, 1'b0, 3'd0, 1'b0, 1'b0, 30'd0,          1'b0}, // R9 slot kept
        {32'd372, 1'b0, 3'd2, 1'b0, 1'b0, 30'h3FFFFE,     1'b0}, // R7 always -> 364
        {32'd376, 1'b0, 3'd1, 1'b0, 1'b1, 30'd1,          1'b0}, // R6
        {32'd364, 1'b1, 3'd0, 1'b0, 1'b0, 30'd0,          1'b1}, // R10 stall on squash
        {32'd364, 1'b1, 3'd0, 1'b0, 1'b0, 30'd0,          1'b0}, // R11 clears
        {32'd368, 1'b0, 3'd4, 1'b0, 1'b0, 30'h3FFFFFF0,   1'b0}, // R9 back -> 304
        {32'd372, 1'b0, 3'd0, 1'b0, 1'b0, 30'd0,          1'b0}, // R9
        {32'd304, 1'b0, 3'd7, 1'b1, 1'b1, 30'd40,         1'b0}, // R12
        {32'd308, 1'b0, 3'd5, 1'b1, 1'b0, 30'd40,         1'b0}  // R12
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic idle();
        stall_i = 1'b0; kind_i = 3'd0; cond_i = 1'b0; annul_i = 1'b0; disp_i = '0;
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        #2000000;
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        rst = 1'b1;
        idle();
        @(negedge clk);
        @(negedge clk);
        chk("R1 pc", fetch_pc_o, 32'd0);
        chk("R1 squash", {31'd0, squash_o}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            logic [68:0] v;
            logic [31:0] exp_link;
            v = VEC[i];
            chk($sformatf("vec%0d pc", i), fetch_pc_o, v[68:37]);
            chk($sformatf("vec%0d squash", i), {31'd0, squash_o}, {31'd0, v[36]});
            kind_i  = v[35:33];
            cond_i  = v[32];
            annul_i = v[31];
            disp_i  = v[30:1];
            stall_i = v[0];
            #1;
            // R9 R10 R11: strobe only for an unsquashed, unstalled call
            exp_link = {31'd0, (v[35:33] == 3'd4) && !v[36] && !v[0]};
            chk($sformatf("vec%0d R9 link_we", i), {31'd0, link_we_o}, exp_link);
            if (exp_link[0])
                chk($sformatf("vec%0d R9 link_addr", i), link_addr_o, v[68:37]);
            @(negedge clk);
        end
        idle();

        // R1: reset mid-run while a squash is pending
        kind_i = 3'd3; annul_i = 1'b1;
        @(negedge clk);
        chk("R8 squash set before reset", {31'd0, squash_o}, 32'd1);
        idle();
        rst = 1'b1;
        @(negedge clk);
        chk("R1 mid-run pc", fetch_pc_o, 32'd0);
        chk("R1 mid-run squash", {31'd0, squash_o}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first advance", fetch_pc_o, 32'd4);
        @(negedge clk);
        chk("R2 second advance", fetch_pc_o, 32'd8);

        // R9: call wraps modulo 2^32 (pc 8 + 4*0x3FFFFFFE = 0)
        kind_i = 3'd4; disp_i = 30'h3FFFFFFE;
        @(negedge clk);
        idle();
        chk("R9 call slot", fetch_pc_o, 32'd12);
        @(negedge clk);
        chk("R9 wrapped target", fetch_pc_o, 32'd0);

        summary();
    end

endmodule